// File: doc/BRIEF.md
# ADC Hardware Start Conditioner

This block sits in front of an ADC conversion sequencer and produces its hardware start command. It has two sources. One is an asynchronous start pin, which is brought into the clock domain and then qualified by a selectable condition: a level (low or high) or an edge (falling or rising). The other is an on-chip PWM trigger pulse, which can be held back by a programmable number of four-clock steps. Every accepted event becomes a start request exactly one clock wide.

A level condition must hold on the synchronized pin for a minimum number of clocks before it counts. An edge condition needs a minimum stable run on both sides of the transition, so short glitches are rejected. Hardware starts are honoured only when the trigger enable is set and the sequencer is configured for one-pass scan operation. Starts are never issued while the sequencer reports busy.

Top module: `adc_trig_cond`

## Requirements
- R1: While reset is asserted, and in the first clock after its release, `startReq` is low.
- R2: `condSel` selects the pin condition: 2'b00 low level, 2'b01 high level, 2'b10 falling edge, 2'b11 rising edge. The target pin level is `condSel[0]`, and `condSel[1]` selects edge operation.
- R3: A level condition fires once the synchronized pin has held the active level for 8 consecutive clocks. A pin change first sampled at clock edge k gives `startReq` high after edge k+10. An active run shorter than 8 clocks gives no start.
- R4: A level condition fires once per assertion. The pin must be seen at the inactive level before the same condition can fire again.
- R5: An edge condition fires only when the pin was stable for at least 4 clocks before the transition and holds the new level for 4 clocks. A transition first sampled at edge k gives `startReq` high after edge k+6. A pulse shorter than 4 clocks gives no start.
- R6: `srcSel` 2'b00 selects the pin and 2'b11 selects the PWM trigger. With 2'b01 or 2'b10, no start is ever issued.
- R7: No start is issued unless `trigEn` is 1 and `opMode` equals 2'b10 (one-pass scan).
- R8: A rising `pwmPulse` first sampled at edge P gives `startReq` high after edge P when `delayVal` is 0, and after edge P+4*`delayVal` otherwise.
- R9: PWM pulses that arrive while a delayed start is pending are ignored. Losing the PWM gate (R6/R7) while a start is pending cancels that start.
- R10: No start is issued in the clock after `seqBusy` is high. A level condition that stays satisfied fires when busy drops. An edge or PWM start that falls due during busy is dropped.
- R11: `startReq` stays high for a single clock per accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | Raw asynchronous start pin |
| pwmPulse | input | 1 | On-chip PWM trigger (rising edge used) |
| trigEn | input | 1 | Hardware trigger enable |
| srcSel | input | 2 | Trigger source select |
| condSel | input | 2 | Pin condition select |
| delayVal | input | 8 | PWM delay in four-clock steps |
| opMode | input | 2 | Sequencer operating mode |
| seqBusy | input | 1 | Sequencer busy |
| startReq | output | 1 | One-clock start request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a level hold of 8 clocks, an edge hold of 4 clocks and four clocks per delay step. With these values every latency is a small fixed number. It places the edges that fall just inside and just outside each hold window, and it uses a PWM delay of 3 steps, which gives a 13-clock start, so the pending-window cases (re-pulse, cancel) fit within a few tens of cycles. A behavioural model predicts `startReq` on every clock, and explicit latency and count checks cover each requirement.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam logic [1:0] SRC_PIN        = 2'b00;
  localparam logic [1:0] SRC_PWM        = 2'b11;
  localparam logic [1:0] MODE_SCAN_ONCE = 2'b10;

  typedef enum logic [1:0] {
    COND_LOW  = 2'b00,
    COND_HIGH = 2'b01,
    COND_FALL = 2'b10,
    COND_RISE = 2'b11
  } condSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDelay;
    logic tickDelay;
  } dpStrobe_t;

endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_SAT     = 8,
  parameter int DELAY_W     = 8,
  parameter int DELAY_STEP  = 4,
  localparam int RUN_W      = $clog2(RUN_SAT + 1),
  localparam int CNT_W      = DELAY_W + $clog2(DELAY_STEP) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin,
  input  logic [DELAY_W-1:0] delayVal,
  input  dpStrobe_t          strobe,
  output logic               pinLvl,
  output logic [RUN_W-1:0]   runLen,
  output logic [RUN_W-1:0]   prevLen,
  output logic               delayDone
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [CNT_W-1:0]       delayCnt;
  logic [CNT_W-1:0]       delayLoad;

  assign syncOut   = syncQ[SYNC_STAGES-1];
  assign delayLoad = CNT_W'(delayVal) * CNT_W'(DELAY_STEP) - CNT_W'(1);
  assign delayDone = (delayCnt == '0);

  // synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
  end

  // run-length tracking of the synchronized pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinLvl  <= 1'b0;
      runLen  <= '0;
      prevLen <= '0;
    end else begin
      pinLvl <= syncOut;
      if (syncOut != pinLvl) begin
        prevLen <= runLen;
        runLen  <= RUN_W'(1);
      end else if (runLen != RUN_W'(RUN_SAT)) begin
        runLen <= runLen + RUN_W'(1);
      end
    end
  end

  // PWM delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 delayCnt <= '0;
    else if (strobe.loadDelay) delayCnt <= delayLoad;
    else if (strobe.tickDelay) delayCnt <= delayCnt - CNT_W'(1);
  end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int LEVEL_HOLD = 8,
  parameter int EDGE_HOLD  = 4,
  parameter int RUN_W      = 4,
  parameter int DELAY_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmPulse,
  input  logic               trigEn,
  input  logic [1:0]         srcSel,
  input  logic [1:0]         condSel,
  input  logic [DELAY_W-1:0] delayVal,
  input  logic [1:0]         opMode,
  input  logic               seqBusy,
  input  logic               pinLvl,
  input  logic [RUN_W-1:0]   runLen,
  input  logic [RUN_W-1:0]   prevLen,
  input  logic               delayDone,
  output dpStrobe_t          strobe,
  output logic               startReq
);

  logic gateBase, pinGate, pwmGate;
  logic activeLvl, isEdge;
  logic levelHit, edgeHit, extFire;
  logic armed, pending, pwmPrev;
  logic pwmRise, acceptPwm, pwmNow, pwmLate, pwmFire;

  assign gateBase  = trigEn && (opMode == MODE_SCAN_ONCE);
  assign pinGate   = gateBase && (srcSel == SRC_PIN);
  assign pwmGate   = gateBase && (srcSel == SRC_PWM);
  assign activeLvl = condSel[0];
  assign isEdge    = condSel[1];

  assign levelHit = !isEdge && armed && (pinLvl == activeLvl) &&
                    (runLen >= RUN_W'(LEVEL_HOLD));
  assign edgeHit  = isEdge && (pinLvl == activeLvl) &&
                    (runLen == RUN_W'(EDGE_HOLD)) &&
                    (prevLen >= RUN_W'(EDGE_HOLD));
  assign extFire  = pinGate && !seqBusy && (levelHit || edgeHit);

  assign pwmRise   = pwmPulse && !pwmPrev;
  assign acceptPwm = pwmGate && pwmRise && !pending;
  assign pwmNow    = acceptPwm && (delayVal == '0);
  assign pwmLate   = pending && pwmGate && delayDone;
  assign pwmFire   = !seqBusy && (pwmNow || pwmLate);

  always_comb begin
    strobe.loadDelay = acceptPwm && (delayVal != '0);
    strobe.tickDelay = pending && !delayDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      pending  <= 1'b0;
      pwmPrev  <= 1'b0;
      startReq <= 1'b0;
    end else begin
      pwmPrev  <= pwmPulse;
      startReq <= extFire || pwmFire;
      if (levelHit && extFire)     armed <= 1'b0;
      else if (pinLvl != activeLvl) armed <= 1'b1;
      if (!pwmGate || pwmLate)     pending <= 1'b0;
      else if (strobe.loadDelay)   pending <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_trig_cond.sv
module adc_trig_cond
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4,
  parameter int DELAY_W     = 8,
  parameter int DELAY_STEP  = 4,
  localparam int RUN_SAT    = (LEVEL_HOLD > EDGE_HOLD) ? LEVEL_HOLD : EDGE_HOLD,
  localparam int RUN_W      = $clog2(RUN_SAT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin,
  input  logic               pwmPulse,
  input  logic               trigEn,
  input  logic [1:0]         srcSel,
  input  logic [1:0]         condSel,
  input  logic [DELAY_W-1:0] delayVal,
  input  logic [1:0]         opMode,
  input  logic               seqBusy,
  output logic               startReq
);

  dpStrobe_t        strobe;
  logic             pinLvl;
  logic [RUN_W-1:0] runLen;
  logic [RUN_W-1:0] prevLen;
  logic             delayDone;

  adc_trig_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .RUN_SAT    (RUN_SAT),
    .DELAY_W    (DELAY_W),
    .DELAY_STEP (DELAY_STEP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .extPin   (extPin),
    .delayVal (delayVal),
    .strobe   (strobe),
    .pinLvl   (pinLvl),
    .runLen   (runLen),
    .prevLen  (prevLen),
    .delayDone(delayDone)
  );

  adc_trig_ctrl #(
    .LEVEL_HOLD(LEVEL_HOLD),
    .EDGE_HOLD (EDGE_HOLD),
    .RUN_W     (RUN_W),
    .DELAY_W   (DELAY_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwmPulse (pwmPulse),
    .trigEn   (trigEn),
    .srcSel   (srcSel),
    .condSel  (condSel),
    .delayVal (delayVal),
    .opMode   (opMode),
    .seqBusy  (seqBusy),
    .pinLvl   (pinLvl),
    .runLen   (runLen),
    .prevLen  (prevLen),
    .delayDone(delayDone),
    .strobe   (strobe),
    .startReq (startReq)
  );

endmodule

// File: rtl/adc_trig_cond_chk.sv
module adc_trig_cond_chk (
  input logic       clk,
  input logic       rstN,
  input logic       extPin,
  input logic       trigEn,
  input logic [1:0] srcSel,
  input logic [1:0] condSel,
  input logic [1:0] opMode,
  input logic       seqBusy,
  input logic       startReq
);

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $past(seqBusy) |-> !startReq);  // R10

  AST_GATE_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> ($past(trigEn) && ($past(opMode) == 2'b10)));  // R7

  AST_SOURCE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (($past(srcSel) == 2'b00) || ($past(srcSel) == 2'b11)));  // R6

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && ($past(srcSel) == 2'b00) && $past(condSel[1])) |->
      (($past(extPin, 4) == $past(condSel[0])) &&
       ($past(extPin, 7) == $past(condSel[0]))));  // R5

endmodule

bind adc_trig_cond adc_trig_cond_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .extPin  (extPin),
  .trigEn  (trigEn),
  .srcSel  (srcSel),
  .condSel (condSel),
  .opMode  (opMode),
  .seqBusy (seqBusy),
  .startReq(startReq)
);

// File: tb/sim_adc_trig_cond.sv
`timescale 1ns/1ps
module sim_adc_trig_cond;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPin = 1'b0;
  logic       pwmPulse = 1'b0;
  logic       trigEn = 1'b1;
  logic [1:0] srcSel = 2'b00;
  logic [1:0] condSel = 2'b11;
  logic [7:0] delayVal = 8'd0;
  logic [1:0] opMode = 2'b10;
  logic       seqBusy = 1'b0;
  logic       startReq;

  always #4 clk = ~clk;

  adc_trig_cond u0 (
    .clk(clk), .rstN(rstN), .extPin(extPin), .pwmPulse(pwmPulse),
    .trigEn(trigEn), .srcSel(srcSel), .condSel(condSel), .delayVal(delayVal),
    .opMode(opMode), .seqBusy(seqBusy), .startReq(startReq)
  );

  int    nChecks = 0;
  int    nFails = 0;
  int    cyc = 0;
  int    startCount = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  // behavioural reference model
  bit    expStart = 1'b0;
  bit    pinHist[$];
  bit    mLast, mArmed, mPend, mPwmPrev;
  int    mRun, mPrevRun, mCnt;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      pinHist.delete();
      mLast = 0; mArmed = 0; mPend = 0; mPwmPrev = 0;
      mRun = 0; mPrevRun = 0; mCnt = 0; expStart = 0;
    end else begin
      bit gb, pg, wg, lvlHit, edgHit, eF, acc, late, pF, newX;
      gb = trigEn && (opMode == 2'b10);
      pg = gb && (srcSel == 2'b00);
      wg = gb && (srcSel == 2'b11);
      lvlHit = !condSel[1] && mArmed && (mLast == condSel[0]) && (mRun >= 8);
      edgHit = condSel[1] && (mLast == condSel[0]) && (mRun == 4) && (mPrevRun >= 4);
      eF   = pg && !seqBusy && (lvlHit || edgHit);
      acc  = wg && pwmPulse && !mPwmPrev && !mPend;
      late = mPend && wg && (mCnt == 0);
      pF   = !seqBusy && ((acc && delayVal == 0) || late);
      expStart = eF || pF;
      if (lvlHit && eF) mArmed = 0;
      else if (mLast != condSel[0]) mArmed = 1;
      if (acc && delayVal != 0) mCnt = 4 * delayVal - 1;
      else if (mPend && mCnt != 0) mCnt = mCnt - 1;
      if (!wg || late) mPend = 0;
      else if (acc && delayVal != 0) mPend = 1;
      mPwmPrev = pwmPulse;
      newX = (pinHist.size() >= 2) ? pinHist[pinHist.size()-2] : 1'b0;
      if (newX != mLast) begin mPrevRun = mRun; mRun = 1; end
      else if (mRun < 8) mRun = mRun + 1;
      mLast = newX;
      pinHist.push_back(extPin);
      if (pinHist.size() > 4) void'(pinHist.pop_front());
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      nChecks++;
      if (startReq !== expStart) begin
        nFails++;
        $display("FAIL %s model compare at cycle %0d: actual=%0b expected=%0b",
                 curTag, cyc, startReq, expStart);
      end
      if (startReq) startCount++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitStart(input int c, input int exp, input string tag);
    int seen = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (startReq) begin seen = cyc - c; break; end
    end
    check(tag, seen, exp);
  endtask

  task automatic countOver(input int n, input int exp, input string tag);
    int base;
    #1 base = startCount;
    tick(n);
    #1 check(tag, startCount - base, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int c;
    // R1 reset
    tick(3);
    check("R1 reset", startReq, 0);
    rstN = 1'b1;
    tick(1);
    check("R1 after release", startReq, 0);
    tick(10);

    // R5 rising edge latency, R11 single pulse
    curTag = "R5";
    c = cyc; extPin = 1'b1;
    waitStart(c, 7, "R5 rising edge latency");
    tick(1);
    check("R11 one clock wide", startReq, 0);
    tick(10);
    extPin = 1'b0;
    countOver(12, 0, "R2 falling edge ignored under rising condition");
    extPin = 1'b1; tick(2); extPin = 1'b0;
    countOver(15, 0, "R5 short glitch rejected");

    // R2 falling edge
    curTag = "R2";
    condSel = 2'b10;
    extPin = 1'b1;
    countOver(12, 0, "R2 rising edge ignored under falling condition");
    c = cyc; extPin = 1'b0;
    waitStart(c, 7, "R2 falling edge latency");
    tick(10);

    // R7 / R6 gating
    curTag = "R7";
    condSel = 2'b11; trigEn = 1'b0;
    extPin = 1'b1; tick(12); extPin = 1'b0;
    countOver(12, 0, "R7 trigger disabled");
    trigEn = 1'b1; opMode = 2'b01;
    extPin = 1'b1; tick(12); extPin = 1'b0;
    countOver(12, 0, "R7 wrong mode");
    opMode = 2'b10;
    curTag = "R6";
    srcSel = 2'b01;
    extPin = 1'b1; tick(12); extPin = 1'b0;
    countOver(12, 0, "R6 reserved source");
    srcSel = 2'b00;
    tick(4);

    // R3 / R4 high level
    curTag = "R3";
    condSel = 2'b01;
    tick(2);
    c = cyc; extPin = 1'b1;
    waitStart(c, 11, "R3 high level latency");
    curTag = "R4";
    countOver(30, 0, "R4 no refire while level held");
    extPin = 1'b0; tick(10);
    c = cyc; extPin = 1'b1;
    waitStart(c, 11, "R4 refire after inactive");
    tick(3);
    extPin = 1'b0; tick(10);
    curTag = "R3";
    extPin = 1'b1; tick(6); extPin = 1'b0;
    countOver(15, 0, "R3 level shorter than hold");

    // R10 busy holds a level request
    curTag = "R10";
    seqBusy = 1'b1; extPin = 1'b1;
    countOver(20, 0, "R10 no start while busy");
    c = cyc; seqBusy = 1'b0;
    waitStart(c, 1, "R10 level fires when busy drops");
    tick(2);

    // R2 low level
    curTag = "R2";
    trigEn = 1'b0; tick(12);
    condSel = 2'b00; tick(3);
    trigEn = 1'b1;
    countOver(5, 0, "R2 low condition idle while pin high");
    c = cyc; extPin = 1'b0;
    waitStart(c, 11, "R2 low level latency");
    tick(15);
    extPin = 1'b1; tick(3);

    // R10 edge dropped during busy
    curTag = "R10";
    condSel = 2'b11;
    extPin = 1'b0; tick(12);
    seqBusy = 1'b1; extPin = 1'b1; tick(15); seqBusy = 1'b0;
    countOver(10, 0, "R10 edge dropped while busy");
    extPin = 1'b0; tick(10);

    // R8 / R9 PWM path
    curTag = "R8";
    srcSel = 2'b11; delayVal = 8'd0;
    c = cyc; pwmPulse = 1'b1;
    @(negedge clk);
    check("R8 zero delay latency", startReq, 1);
    check("R8 zero delay cycle", cyc - c, 1);
    pwmPulse = 1'b0;
    tick(5);
    delayVal = 8'd3;
    c = cyc; pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    tick(3); pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    begin
      int seen = -1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (startReq && seen < 0) seen = cyc - c;
      end
      check("R8 delay of 3 steps", seen, 13);
    end
    curTag = "R9";
    c = cyc; pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    tick(3); pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    countOver(30, 1, "R9 pulse during pending ignored");
    delayVal = 8'd5;
    pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    tick(5); trigEn = 1'b0; tick(1);
    countOver(30, 0, "R9 pending cancelled by gate loss");
    trigEn = 1'b1; delayVal = 8'd0;
    tick(2);
    curTag = "R10";
    seqBusy = 1'b1; pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    countOver(5, 0, "R10 pwm start dropped while busy");
    seqBusy = 1'b0;
    curTag = "R6";
    srcSel = 2'b00; tick(2);
    pwmPulse = 1'b1; tick(1); pwmPulse = 1'b0;
    countOver(5, 0, "R6 pwm ignored with pin source");
    tick(5);
    finishRun();
  end

endmodule